// File: doc/BRIEF.md
# Two-Bank Interrupt Controller

This block collects 64 interrupt inputs and drives two request lines to a processor: a normal request and a fast request. Sources 0-31 form the low bank and sources 32-63 the high bank. Each register exists once per bank. The low-bank copy sits at a base offset and the high-bank copy sits four bytes above it, so the pairs are interleaved at an eight-byte stride.

Each source is fixed at build time as level-followed or edge-latched. Edge sources pass through a synchronizer, and a rising edge on the synchronized input sets a sticky latch. Software then clears the latch with a write-one-to-clear register. Enables and software triggers are paired write-one-to-set and write-one-to-clear registers, so a zero bit leaves the state as it was. A per-source route bit sends a pending, enabled source to either request line.

The register port is a plain strobe: one access per cycle, with no wait states and no back-pressure. A write takes effect on the clock edge where `bus_valid` and `bus_write` are both high. Read data is combinational from `bus_addr`, and a read has no side effect. `irq_o` and `fiq_o` are combinational from the registered state.

Top module: `twin_bank_intc`

## Requirements
- R1: Byte address bits [7:3] select the register and bit 2 selects the bank (0 = sources 0-31, 1 = sources 32-63); bits [1:0] are ignored. Offsets 0x48-0x54 and every offset above 0x64 read as zero and ignore writes. The status and sense offsets also ignore writes.
- R2: A write to enable-set (0x20/0x24) ORs the data into the enable mask. A write to enable-clear (0x28/0x2C) clears the bits that are 1 in the data. Both offsets read back the current mask.
- R3: Trigger-set (0x30/0x34) and trigger-clear (0x38/0x3C) set and clear a software trigger bit in the same way, and both read it back. A set trigger bit makes its source pending whatever its input does.
- R4: The route register (0x18/0x1C) is read/write. A bit of 0 sends the source to `irq_o` and a bit of 1 sends it to `fiq_o`.
- R5: The sense register (0x40/0x44) reads back the `LEVEL_MASK` parameter slice for its bank, where 1 = level and 0 = edge. Writes to it are ignored.
- R6: For an edge source, a 0-to-1 change of the input sets the source's latch three clock edges later. The latch stays set after the input falls and reads at 0x60/0x64.
- R7: Writing 1s to edge-clear (0x58/0x5C) clears those latches. If a rising edge arrives in the same cycle as the clear, the rising edge wins. Edge-clear has no effect on level sources, and the offset reads as zero.
- R8: A level source is pending while its synchronized input is high, which is two clock edges after the input. Its latch-status bit always reads 0.
- R9: Raw status (0x10/0x14) shows the pending state, before enable or route, ORed with the software trigger.
- R10: IRQ status (0x00/0x04) is raw AND enable AND route=0. FIQ status (0x08/0x0C) is raw AND enable AND route=1.
- R11: `irq_o` is high when any IRQ status bit in either bank is set, and `fiq_o` is high when any FIQ status bit is set.
- R12: Reset clears enable, trigger, route and all latches, and drives both request lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Interrupt source inputs, may be asynchronous |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with `LEVEL_MASK = 64'h8000_0F00_00F0_0001` and two synchronizer stages. This mask places level sources at both extreme bits (0 and 63) and in the middle of both banks. Edge and level behaviour can therefore be checked side by side in each bank, including edge-clear writes that hit level bits. Random toggling of the inputs and random register writes exercise the set/clear pairs and the routing across both banks. A full register sweep is compared against a bench model after every step.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int BANK_W = 32;
  localparam int NBANK  = 2;
  localparam int NSRC   = NBANK * BANK_W;

  // register index = byte address [7:3]
  localparam int REG_IRQ   = 0;
  localparam int REG_FIQ   = 1;
  localparam int REG_RAW   = 2;
  localparam int REG_ROUTE = 3;
  localparam int REG_ENS   = 4;
  localparam int REG_ENC   = 5;
  localparam int REG_TGS   = 6;
  localparam int REG_TGC   = 7;
  localparam int REG_SENSE = 8;
  localparam int REG_ECLR  = 11;
  localparam int REG_LATCH = 12;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic trg_set;
    logic trg_clr;
    logic route_wr;
    logic edge_clr;
  } bank_wr_t;

  typedef struct packed {
    logic [BANK_W-1:0] irq;
    logic [BANK_W-1:0] fiq;
    logic [BANK_W-1:0] raw;
    logic [BANK_W-1:0] route;
    logic [BANK_W-1:0] en;
    logic [BANK_W-1:0] trig;
    logic [BANK_W-1:0] sense;
    logic [BANK_W-1:0] latch;
  } bank_view_t;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter logic [BANK_W-1:0] LEVEL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] src_s,
  input  bank_wr_t          wr,
  input  logic [BANK_W-1:0] wdata,
  output bank_view_t        view
);

  logic [BANK_W-1:0] en_q, trig_q, route_q, prev_q, latch_q;
  logic [BANK_W-1:0] latch_nxt, pend;

  // per-source variant chosen by the sense parameter
  for (genvar i = 0; i < BANK_W; i++) begin : g_src
    if (LEVEL[i]) begin : g_level
      assign latch_nxt[i] = 1'b0;
      assign pend[i]      = src_s[i];
    end else begin : g_edge
      // a rising edge takes priority over a clear in the same cycle
      assign latch_nxt[i] = (src_s[i] & ~prev_q[i]) |
                            (latch_q[i] & ~(wr.edge_clr & wdata[i]));
      assign pend[i]      = latch_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      trig_q  <= '0;
      route_q <= '0;
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= src_s;
      latch_q <= latch_nxt;
      if (wr.en_set)       en_q <= en_q | wdata;
      else if (wr.en_clr)  en_q <= en_q & ~wdata;
      if (wr.trg_set)      trig_q <= trig_q | wdata;
      else if (wr.trg_clr) trig_q <= trig_q & ~wdata;
      if (wr.route_wr)     route_q <= wdata;
    end
  end

  logic [BANK_W-1:0] raw, live;
  assign raw  = pend | trig_q;
  assign live = raw & en_q;

  assign view.raw   = raw;
  assign view.irq   = live & ~route_q;
  assign view.fiq   = live & route_q;
  assign view.route = route_q;
  assign view.en    = en_q;
  assign view.trig  = trig_q;
  assign view.sense = LEVEL;
  assign view.latch = latch_q;

endmodule

// File: rtl/intc_regif.sv
module intc_regif
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                         bus_valid,
  input  logic                         bus_write,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  bank_view_t [NBANK-1:0]       view,
  output bank_wr_t   [NBANK-1:0]       wr,
  output logic       [BANK_W-1:0]      rdata
);

  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             bank;
  logic             addr_unused;

  assign idx         = bus_addr[ADDR_W-1:3];
  assign bank        = bus_addr[2];
  assign addr_unused = &{1'b0, bus_addr[1:0]};

  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    logic hit;
    assign hit = bus_valid && bus_write && (bank == b[0]);
    assign wr[b].en_set   = hit && (idx == IDX_W'(REG_ENS));
    assign wr[b].en_clr   = hit && (idx == IDX_W'(REG_ENC));
    assign wr[b].trg_set  = hit && (idx == IDX_W'(REG_TGS));
    assign wr[b].trg_clr  = hit && (idx == IDX_W'(REG_TGC));
    assign wr[b].route_wr = hit && (idx == IDX_W'(REG_ROUTE));
    assign wr[b].edge_clr = hit && (idx == IDX_W'(REG_ECLR));
  end

  bank_view_t sel_v;
  assign sel_v = view[bank];

  always_comb begin
    rdata = '0;
    case (idx)
      IDX_W'(REG_IRQ):   rdata = sel_v.irq;
      IDX_W'(REG_FIQ):   rdata = sel_v.fiq;
      IDX_W'(REG_RAW):   rdata = sel_v.raw;
      IDX_W'(REG_ROUTE): rdata = sel_v.route;
      IDX_W'(REG_ENS),
      IDX_W'(REG_ENC):   rdata = sel_v.en;
      IDX_W'(REG_TGS),
      IDX_W'(REG_TGC):   rdata = sel_v.trig;
      IDX_W'(REG_SENSE): rdata = sel_v.sense;
      IDX_W'(REG_LATCH): rdata = sel_v.latch;
      default:           rdata = '0;
    endcase
  end

endmodule

// File: rtl/twin_bank_intc.sv
module twin_bank_intc
  import intc_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NSRC-1:0]   LEVEL_MASK  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);

  logic [NSRC-1:0] src_s;
  logic [NSRC-1:0] en_all, route_all, latch_all, irq_all, fiq_all;

  bank_view_t [NBANK-1:0] view;
  bank_wr_t   [NBANK-1:0] wr;

  intc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (src_i),
    .q    (src_s)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    intc_bank #(.LEVEL(LEVEL_MASK[b*BANK_W +: BANK_W])) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .src_s(src_s[b*BANK_W +: BANK_W]),
      .wr   (wr[b]),
      .wdata(bus_wdata),
      .view (view[b])
    );
    assign en_all   [b*BANK_W +: BANK_W] = view[b].en;
    assign route_all[b*BANK_W +: BANK_W] = view[b].route;
    assign latch_all[b*BANK_W +: BANK_W] = view[b].latch;
    assign irq_all  [b*BANK_W +: BANK_W] = view[b].irq;
    assign fiq_all  [b*BANK_W +: BANK_W] = view[b].fiq;
  end

  intc_regif #(.ADDR_W(ADDR_W)) u_regif (
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .view     (view),
    .wr       (wr),
    .rdata    (bus_rdata)
  );

  assign irq_o = |irq_all;
  assign fiq_o = |fiq_all;

endmodule

// File: rtl/twin_bank_intc_chk.sv
module twin_bank_intc_chk #(
  parameter logic [63:0] LEVEL_MASK = '0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [63:0] src_s,
  input logic [63:0] en_all,
  input logic [63:0] route_all,
  input logic [63:0] latch_all,
  input logic [63:0] irq_all,
  input logic [63:0] fiq_all,
  input logic        irq_o,
  input logic        fiq_o
);

  logic [63:0] seen_q;
  logic [63:0] rise_v;
  logic        wr_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= src_s;
  end

  assign rise_v = src_s & ~seen_q & ~LEVEL_MASK;
  assign wr_any = bus_valid && bus_write;

  assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr[7:2] == 6'h08) |=>
      ((en_all[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr[7:2] == 6'h0B) |=>
      ((en_all[63:32] & $past(bus_wdata)) == 32'h0));

  assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_any && (bus_addr[7:3] == 5'd4 || bus_addr[7:3] == 5'd5)) |=>
      $stable(en_all));

  assert_route_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr[7:2] == 6'h06) |=> (route_all[31:0] == $past(bus_wdata)));

  assert_edge_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_v != 64'h0) |=> ((latch_all & $past(rise_v)) == $past(rise_v)));

  assert_edge_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr[7:2] == 6'h16 && rise_v[31:0] == 32'h0) |=>
      ((latch_all[31:0] & $past(bus_wdata)) == 32'h0));

  assert_route_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_all & fiq_all) == 64'h0));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == 64'h0) |-> (!irq_o && !fiq_o));

endmodule

bind twin_bank_intc twin_bank_intc_chk #(.LEVEL_MASK(LEVEL_MASK)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_valid(bus_valid),
  .bus_write(bus_write),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .src_s    (src_s),
  .en_all   (en_all),
  .route_all(route_all),
  .latch_all(latch_all),
  .irq_all  (irq_all),
  .fiq_all  (fiq_all),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o)
);

// File: tb/twin_bank_intc_tb_top.sv
module twin_bank_intc_tb_top;

  localparam logic [63:0] LVL = 64'h8000_0F00_00F0_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [63:0] m_en = '0, m_trig = '0, m_route = '0, m_latch = '0, m_src = '0;

  always #2 clk = ~clk;

  twin_bank_intc #(.ADDR_W(8), .SYNC_STAGES(2), .LEVEL_MASK(LVL)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_valid(valid), .bus_write(write),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] m_raw();
    return m_latch | (m_src & LVL) | m_trig;
  endfunction

  function automatic logic [31:0] exp_reg(input logic [7:0] a);
    logic [63:0] v;
    int b = a[2] ? 32 : 0;
    case (a[7:3])
      5'd0: v = m_raw() & m_en & ~m_route;
      5'd1: v = m_raw() & m_en & m_route;
      5'd2: v = m_raw();
      5'd3: v = m_route;
      5'd4, 5'd5: v = m_en;
      5'd6, 5'd7: v = m_trig;
      5'd8: v = LVL;
      5'd12: v = m_latch;
      default: v = '0;
    endcase
    return v[b +: 32];
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a[7:3])
      5'd0, 5'd1: return "R10";
      5'd2: return "R9";
      5'd3: return "R4";
      5'd4, 5'd5: return "R2";
      5'd6, 5'd7: return "R3";
      5'd8: return "R5";
      5'd12: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    int b = a[2] ? 32 : 0;
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
    case (a[7:3])
      5'd3: m_route[b +: 32] = d;
      5'd4: m_en[b +: 32] = m_en[b +: 32] | d;
      5'd5: m_en[b +: 32] = m_en[b +: 32] & ~d;
      5'd6: m_trig[b +: 32] = m_trig[b +: 32] | d;
      5'd7: m_trig[b +: 32] = m_trig[b +: 32] & ~d;
      5'd11: m_latch[b +: 32] = m_latch[b +: 32] & ~d;
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic drive_src(input logic [63:0] n);
    @(negedge clk);
    m_latch = m_latch | (n & ~m_src & ~LVL);
    m_src = n;
    src = n;
    repeat (4) @(posedge clk);
  endtask

  task automatic sweep();
    logic [31:0] d;
    for (int k = 0; k < 28; k++) begin
      bus_rd(8'(k * 4), d);
      check(req_of(8'(k * 4)), d, exp_reg(8'(k * 4)));
    end
    check("R11 irq_o", {31'h0, irq}, {31'h0, |(m_raw() & m_en & ~m_route)});
    check("R11 fiq_o", {31'h0, fiq}, {31'h0, |(m_raw() & m_en & m_route)});
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R12 reset state
    bus_rd(8'h20, d); check("R12 enable lo", d, 32'h0);
    bus_rd(8'h1C, d); check("R12 route hi", d, 32'h0);
    bus_rd(8'h64, d); check("R12 latch hi", d, 32'h0);
    check("R12 irq_o", {31'h0, irq}, 32'h0);
    sweep();

    // R5 sense is read only
    bus_wr(8'h40, 32'hFFFF_FFFF);
    bus_rd(8'h40, d); check("R5 sense lo", d, LVL[31:0]);
    bus_rd(8'h44, d); check("R5 sense hi", d, LVL[63:32]);

    // R6 edge source bit 2 latches and holds after the input falls
    drive_src(64'h4);
    bus_rd(8'h60, d); check("R6 latch set", d, 32'h4);
    drive_src(64'h0);
    bus_rd(8'h60, d); check("R6 latch held", d, 32'h4);
    bus_rd(8'h10, d); check("R9 raw held", d, 32'h4);
    bus_wr(8'h20, 32'h4);
    check("R11 irq_o on", {31'h0, irq}, 32'h1);
    bus_wr(8'h18, 32'h4);
    check("R4 irq_o off", {31'h0, irq}, 32'h0);
    check("R4 fiq_o on", {31'h0, fiq}, 32'h1);
    bus_rd(8'h08, d); check("R10 fiq status", d, 32'h4);
    bus_wr(8'h58, 32'h4);
    bus_rd(8'h60, d); check("R7 latch cleared", d, 32'h0);

    // R8 level source bit 0, edge-clear has no effect on it
    drive_src(64'h1);
    bus_rd(8'h10, d); check("R8 level raw", d, 32'h1);
    bus_rd(8'h60, d); check("R8 level latch", d, 32'h0);
    bus_wr(8'h58, 32'h1);
    bus_rd(8'h10, d); check("R7 level untouched", d, 32'h1);
    drive_src(64'h0);
    bus_rd(8'h10, d); check("R8 level drop", d, 32'h0);

    // R3 software trigger on bit 63
    bus_wr(8'h34, 32'h8000_0000);
    bus_wr(8'h24, 32'h8000_0000);
    bus_rd(8'h04, d); check("R3 trig irq hi", d, 32'h8000_0000);
    bus_wr(8'h3C, 32'h8000_0000);
    bus_rd(8'h14, d); check("R3 trig cleared", d, 32'h0);

    // R1 reserved offsets
    bus_wr(8'h48, 32'hFFFF_FFFF);
    bus_rd(8'h48, d); check("R1 reserved", d, 32'h0);
    bus_rd(8'h70, d); check("R1 beyond map", d, 32'h0);
    sweep();

    // random mix
    for (int it = 0; it < 250; it++) begin
      int op = $urandom_range(0, 5);
      if (op == 0) drive_src(m_src ^ (64'($urandom) << $urandom_range(0, 32)) & {$urandom, $urandom});
      else bus_wr(8'($urandom_range(0, 29) * 4), $urandom & $urandom);
      sweep();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule